// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block turns single requests from an on-chip master into read or write cycles on an external parallel memory bus. The bus carries a 20-bit address, which is a 16-bit offset plus a 4-bit bank field, two active-low strobes (one for reads, one for writes), and an 8-bit bidirectional data bus. The block also emits a bus clock at one quarter of the oscillator rate. Slow devices can stretch a cycle by pulling an active-low wait input.

The block is clocked at twice the oscillator frequency. One clock period, called a tick below, is therefore half an oscillator period. Every bus cycle is aligned to the bus clock, which is a divide-by-8 of the block clock. The address is launched on a rising edge of the bus clock. The strobe falls two ticks later and stays low for five ticks. It then rises, and the address is held for one more tick. The requester raises `req` with its address, data and direction, and holds all of them until the one-tick `done` pulse. For reads, `rdata` is valid while `done` is high.

Top module: `ebus_cycle_gen`

## Requirements
- R1: `bus_clk` has a period of 8 ticks: it is high for 4 ticks and then low for 4 ticks.
- R2: While reset is active, `bus_rd_n` and `bus_wr_n` are 1, `bus_d_oe` and `done` are 0, and `bus_clk` is 1.
- R3: The full 20-bit request address is on the bus at least 2 ticks before the strobe falls. Bits 19:16 of `req_addr` appear on `bus_bank` and bits 15:0 appear on `bus_a`.
- R4: Only one strobe is active in a cycle: `bus_rd_n` for a read (`req_write`=0) and `bus_wr_n` for a write (`req_write`=1). With no wait, that strobe is low for exactly 5 ticks.
- R5: The address does not change while a strobe is low, nor in the tick after the strobe rises.
- R6: In a write cycle, `bus_d_oe` is 1 and `bus_d` carries `req_wdata` from the address launch until one tick after the write strobe rises. This is at least 4 ticks before that rise. In read cycles and when idle, `bus_d_oe` is 0 and the block leaves `bus_d` undriven.
- R7: At least 3 ticks pass between the rise of one strobe and the fall of the next.
- R8: `bus_wait_n` is sampled on each falling edge of `bus_clk` while a strobe is low. Each sample of 0 lengthens the strobe by 8 ticks, so the strobe always rises on the same bus clock phase.
- R9: `done` is high for exactly one tick: the tick just after the strobe rises. For a read, `rdata` holds the value that was on `bus_d` at the clock edge where `bus_rd_n` rose, even if the bus value changed earlier in the strobe.
- R10: A request is taken only when the block is idle and the bus clock is in its last tick. The address change therefore coincides with a rising edge of `bus_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Cycle request, held until `done` |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 20 | Bank (19:16) and offset (15:0) |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-tick completion pulse |
| rdata | output | 8 | Data captured in a read cycle |
| bus_clk | output | 1 | Quarter-oscillator bus clock |
| bus_a | output | 16 | Address offset |
| bus_bank | output | 4 | Address bank field |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_d | inout | 8 | Bidirectional data bus |
| bus_d_oe | output | 1 | 1 while the block drives `bus_d` |
| bus_wait_n | input | 1 | Cycle stretch request, active low |

## Verification
The assertions assume that the requester keeps `req`, `req_write`, `req_addr` and `req_wdata` steady from the moment it raises `req` until `done`. They also assume that `bus_wait_n` is a clean signal, synchronous to `clk`, and that the external device holds read data stable across the edge where the read strobe rises. The bench changes every input only on falling clock edges. It drops `req` in the tick in which it sees `done`. It drives read data only while the read strobe is low, and releases it after the capturing edge. It lowers `bus_wait_n` when the strobe falls and raises it again after counting the required number of falling edges of `bus_clk`.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] ph_t;
  localparam int CYC_TICKS = 1 << PH_W;

  localparam ph_t PH_LAUNCH = ph_t'(CYC_TICKS - 1);
  localparam ph_t PH_ARM    = 3'd1;
  localparam ph_t PH_LOW0   = 3'd2;
  localparam ph_t PH_WSMP   = ph_t'(CYC_TICKS / 2 - 1);
  localparam ph_t PH_LAST   = ph_t'(CYC_TICKS - 2);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } ebus_state_t;
endpackage

// File: rtl/ebus_rst_sync.sv
module ebus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/ebus_phase_gen.sv
module ebus_phase_gen
  import ebus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output ph_t  ph,
  output logic bus_clk
);
  ph_t ph_q;
  ph_t ph_d;

  always_comb begin
    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph      = ph_q;
  assign bus_clk = ~ph_q[PH_W-1];

  assert_clk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |-> $past(bus_clk) == 1'b0 && ph_q == '0);
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ph_t           ph,
  input  logic          req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] din,
  input  logic          wait_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          oe,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata
);
  ebus_state_t st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rdat_q;
  logic          dir_q, oe_q, oe_d, rd_n_q, rd_n_d, wr_n_q, wr_n_d;
  logic          done_q, done_d, wt_q, wt_d;
  logic          ld_en, cap_en;

  always_comb begin
    st_d   = st_q;
    oe_d   = oe_q;
    rd_n_d = rd_n_q;
    wr_n_d = wr_n_q;
    done_d = 1'b0;
    wt_d   = wt_q;
    ld_en  = 1'b0;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req && ph == PH_LAUNCH) begin
          st_d  = ST_SETUP;
          ld_en = 1'b1;
          oe_d  = req_write;
        end
      end
      ST_SETUP: begin
        if (ph == PH_ARM) begin
          st_d   = ST_STROBE;
          rd_n_d = dir_q;
          wr_n_d = ~dir_q;
          wt_d   = 1'b0;
        end
      end
      ST_STROBE: begin
        if (ph == PH_WSMP) wt_d = ~wait_n;
        if (ph == PH_LAST && !wt_q) begin
          st_d   = ST_HOLD;
          rd_n_d = 1'b1;
          wr_n_d = 1'b1;
          done_d = 1'b1;
          cap_en = ~dir_q;
        end
      end
      default: begin
        st_d = ST_IDLE;
        oe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      oe_q   <= 1'b0;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      done_q <= 1'b0;
      wt_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      oe_q   <= oe_d;
      rd_n_q <= rd_n_d;
      wr_n_q <= wr_n_d;
      done_q <= done_d;
      wt_q   <= wt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      dir_q  <= 1'b0;
    end else if (ld_en) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
      dir_q  <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdat_q <= '0;
    else if (cap_en) rdat_q <= din;
  end

  assign addr  = addr_q;
  assign dout  = wd_q;
  assign oe    = oe_q;
  assign rd_n  = rd_n_q;
  assign wr_n  = wr_n_q;
  assign done  = done_q;
  assign rdata = rdat_q;

  logic stb_low;
  logic [1:0] gap_q;
  assign stb_low = ~rd_n_q | ~wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap_q <= 2'd3;
    else if (stb_low)       gap_q <= 2'd0;
    else if (gap_q != 2'd3) gap_q <= gap_q + 2'd1;
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_q && !wr_n_q));
  assert_fall_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n_q) || $fell(wr_n_q)) |-> ph == PH_LOW0);
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_low |=> $stable(addr_q));
  assert_oe_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_q |-> !oe_q) and (!wr_n_q |-> oe_q));
  assert_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n_q) || $fell(wr_n_q)) |-> gap_q == 2'd3);
  assert_rise_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n_q) || $rose(wr_n_q)) |-> ph == PH_LAUNCH);
  assert_done_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n_q) || $rose(wr_n_q)) |-> done_q);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/ebus_cycle_gen.sv
module ebus_cycle_gen
  import ebus_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 4,
  parameter int DW     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    req_write,
  input  logic [OFS_W+BANK_W-1:0] req_addr,
  input  logic [DW-1:0]           req_wdata,
  output logic                    done,
  output logic [DW-1:0]           rdata,
  output logic                    bus_clk,
  output logic [OFS_W-1:0]        bus_a,
  output logic [BANK_W-1:0]       bus_bank,
  output logic                    bus_rd_n,
  output logic                    bus_wr_n,
  inout  wire  [DW-1:0]           bus_d,
  output logic                    bus_d_oe,
  input  logic                    bus_wait_n
);
  localparam int AW = OFS_W + BANK_W;

  logic          rst_i_n;
  ph_t           ph;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout;
  logic          oe;

  ebus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ebus_phase_gen u_ph (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ph      (ph),
    .bus_clk (bus_clk)
  );

  ebus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ph        (ph),
    .req       (req),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .din       (bus_d),
    .wait_n    (bus_wait_n),
    .addr      (addr),
    .dout      (dout),
    .oe        (oe),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .done      (done),
    .rdata     (rdata)
  );

  assign bus_a    = addr[OFS_W-1:0];
  assign bus_bank = addr[AW-1:OFS_W];
  assign bus_d_oe = oe;
  assign bus_d    = oe ? dout : {DW{1'bz}};
endmodule

// File: tb/sim_ebus_cycle_gen.sv
`timescale 1ns/1ps
module sim_ebus_cycle_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic        bus_clk;
  logic [15:0] bus_a;
  logic [3:0]  bus_bank;
  logic        bus_rd_n, bus_wr_n, bus_d_oe;
  logic        bus_wait_n = 1'b1;
  wire  [7:0]  bus_d;
  logic        tb_drv = 1'b0;
  logic [7:0]  tb_val = '0;

  int checks = 0;
  int fails = 0;
  int tick = 0;
  int g_fall = 0;
  int g_rise = 0;

  assign bus_d = tb_drv ? tb_val : 8'bz;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick = tick + 1;

  ebus_cycle_gen u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .bus_clk(bus_clk), .bus_a(bus_a), .bus_bank(bus_bank),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_d(bus_d),
    .bus_d_oe(bus_d_oe), .bus_wait_n(bus_wait_n)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string rq, input string what, input longint act, input longint lim);
    checks++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected>=%0d", rq, what, act, lim);
    end
  endtask

  task automatic do_cycle(input bit wr, input logic [19:0] a, input logic [7:0] wd,
                          input logic [7:0] rv, input int nw);
    int t_addr, t_fall, t_oe, falls;
    bit prev_clk, prev_stb, stb, oth_low, oe_read, fin, done_early;
    logic [19:0] prev_a;
    t_addr = -1; t_fall = -1; t_oe = -1; falls = 0;
    oth_low = 0; oe_read = 0; fin = 0; done_early = 0;
    @(negedge clk);
    prev_clk = bus_clk; prev_a = {bus_bank, bus_a}; prev_stb = 1'b1;
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    for (int t = 1; t < 200; t++) begin
      @(negedge clk);
      stb = wr ? bus_wr_n : bus_rd_n;
      if (!(wr ? bus_rd_n : bus_wr_n)) oth_low = 1;
      if (bus_d_oe && t_oe < 0) t_oe = t;
      if (!wr && bus_d_oe) oe_read = 1;
      if (t_addr < 0 && {bus_bank, bus_a} != prev_a) begin
        t_addr = t;
        chk("R10", "bus_clk rising with address launch", {prev_clk, bus_clk}, 2'b01);
      end
      if (prev_stb && !stb) begin
        t_fall = t; g_fall = tick;
        chk_ge("R3", "address lead before strobe", t_fall - t_addr, 2);
        chk("R3", "bank and offset at strobe fall", {bus_bank, bus_a}, a);
        if (wr) chk("R6", "write data at strobe fall", {bus_d_oe, bus_d}, {1'b1, wd});
        else begin tb_drv = 1'b1; tb_val = ~rv; end
        if (nw > 0) bus_wait_n = 1'b0;
      end else if (!prev_stb && !stb) begin
        if (!wr && t == t_fall + 2) tb_val = rv;
        if (prev_clk && !bus_clk) begin
          falls++;
          if (falls >= nw) bus_wait_n = 1'b1;
        end
        chk("R5", "address steady during strobe", {bus_bank, bus_a}, a);
        if (done) done_early = 1;
      end else if (!prev_stb && stb) begin
        g_rise = tick;
        chk("R8", "strobe low ticks", t - t_fall, 5 + 8 * nw);
        chk("R5", "address one tick after rise", {bus_bank, bus_a}, a);
        chk("R9", "done in tick after rise", done, 1);
        if (wr) chk_ge("R6", "write drive lead before rise", t - t_oe, 4);
        else chk("R9", "read data captured at rise", rdata, rv);
        req = 1'b0; tb_drv = 1'b0; bus_wait_n = 1'b1;
        fin = 1;
        break;
      end
      prev_clk = bus_clk; prev_stb = stb;
    end
    chk("R4", "cycle completed", fin, 1);
    chk("R4", "opposite strobe stayed high", oth_low, 0);
    chk("R9", "done not early", done_early, 0);
    if (!wr) chk("R6", "no drive in read", oe_read, 0);
    @(negedge clk);
    chk("R9", "done single tick", done, 0);
    chk("R6", "drive released after cycle", bus_d_oe, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "reset strobes", {bus_rd_n, bus_wr_n}, 2'b11);
    chk("R2", "reset drive and done", {bus_d_oe, done}, 2'b00);
    chk("R2", "reset bus_clk", bus_clk, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clock();
    bit p;
    int hi, lo;
    p = bus_clk;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!p && bus_clk) break;
      p = bus_clk;
    end
    for (int k = 0; k < 2; k++) begin
      hi = 0; lo = 0;
      while (bus_clk) begin hi++; @(negedge clk); end
      while (!bus_clk) begin lo++; @(negedge clk); end
      chk("R1", "bus_clk high ticks", hi, 4);
      chk("R1", "bus_clk low ticks", lo, 4);
    end
  endtask

  task automatic t_read_plain();  do_cycle(1'b0, 20'h3_1234, 8'h00, 8'hA5, 0); endtask
  task automatic t_write_plain(); do_cycle(1'b1, 20'hC_BEEF, 8'h5A, 8'h00, 0); endtask
  task automatic t_read_wait();   do_cycle(1'b0, 20'h7_0F0F, 8'h00, 8'h3C, 1); endtask
  task automatic t_write_wait();  do_cycle(1'b1, 20'h1_8001, 8'hC3, 8'h00, 2); endtask

  task automatic t_bank();
    do_cycle(1'b0, 20'hF_0001, 8'h00, 8'h96, 0);
    chk("R3", "bank field top value", bus_bank, 4'hF);
    chk("R3", "offset field", bus_a, 16'h0001);
  endtask

  task automatic t_back_to_back();
    int r;
    do_cycle(1'b1, 20'h2_2222, 8'h11, 8'h00, 0);
    r = g_rise;
    do_cycle(1'b0, 20'h4_4444, 8'h00, 8'h22, 0);
    chk_ge("R7", "ticks between strobes", g_fall - r, 3);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_clock();
    t_read_plain();
    t_write_plain();
    t_read_wait();
    t_write_wait();
    t_bank();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule